// File: doc/BRIEF.md
# Three-Bus Voice Accumulation Mixer

This block sums the contributions of up to 64 voices into one output frame at the 48 kHz frame rate. Each voice arrives with six lanes of signed 18-bit sample data, already scaled by the envelope stage: main left, main right, reverb-send left, reverb-send right, chorus-send left and chorus-send right. Each lane has its own 26-bit accumulator, which leaves enough headroom that 64 full-scale voices never wrap inside the sum. The frame controller clears all six accumulators when a frame starts. It counts the voices it accepts and closes the frame when told to.

When a frame closes, every accumulator is reduced to an output word. A software-visible mode picks the width: a 20-bit word or a 16-bit word. The reduction rounds half-up, then clamps to the extreme code of the selected width instead of wrapping. All six words are presented together with a one-cycle valid strobe. The main-bus left/right pair is also pushed into an 8-entry queue, which the codec-link serializer drains on its own schedule. The mixer can therefore run several frames ahead of the consumer. It refuses to start a new frame while the queue is full.

Top module: `voice_bus_mixer`

## Requirements
- R1: After reset, `frame_ready` is 1, `fifo_empty` is 1, `fifo_full` is 0, and `out_valid`, `fifo_underrun`, `bus_out` and `fifo_data` are all 0.
- R2: A frame opens on a `frame_start` that is accepted while `frame_ready` is 1, and that start clears all six accumulators. Every `voice_valid` cycle after the start, up to and including the cycle that carries `frame_done`, adds each 18-bit lane of `voice_lanes`, sign-extended, to its own lane accumulator. Lane k of `voice_lanes` occupies bits [18k+17:18k], in this order: 0 main L, 1 main R, 2 reverb L, 3 reverb R, 4 chorus L, 5 chorus R.
- R3: Only the first 64 voices of a frame are added. Any further `voice_valid` cycles in the same frame have no effect on the sums.
- R4: With `fmt_wide`=1, each result is floor((A+2)/4) clamped to [-524288, 524287], where A is the accumulator.
- R5: With `fmt_wide`=0, each result is floor((A+32)/64) clamped to [-32768, 32767] and sign-extended to 20 bits.
- R6: `out_valid` pulses for exactly one cycle, two clock edges after the edge that accepts `frame_done`. The word of lane k appears on `bus_out[20k+19:20k]`, uses the format selected by `fmt_wide` in the cycle before the pulse, and holds until the next frame's results replace it.
- R7: Together with each `out_valid`, the queue receives the pair {main L, main R}, with left in bits [39:20]. Pairs leave the queue in the order they entered.
- R8: `frame_ready` is 0 while a frame is in progress or the 8-entry queue is full. A `frame_start` given while `frame_ready` is 0 is ignored and does not clear the sums.
- R9: A `fifo_rd` pulse while the queue is not empty places the oldest pair on `fifo_data` after the next clock edge and removes it from the queue.
- R10: A `fifo_rd` pulse while the queue is empty leaves `fifo_data` at the last pair read and sets `fifo_underrun`, which stays 1 until reset.
- R11: `voice_valid` and `frame_done` have no effect outside an open frame: no sum changes and no `out_valid` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_wide | input | 1 | 1 selects 20-bit output words, 0 selects 16-bit |
| frame_start | input | 1 | Request to open a frame |
| frame_done | input | 1 | Closes the open frame |
| voice_valid | input | 1 | A voice's six lanes are present on `voice_lanes` |
| voice_lanes | input | 108 | Six signed 18-bit lane contributions |
| frame_ready | output | 1 | A `frame_start` would be accepted now |
| out_valid | output | 1 | One-cycle strobe: new frame results on `bus_out` |
| bus_out | output | 120 | Six 20-bit formatted lane results |
| fifo_rd | input | 1 | Pop one main-bus pair |
| fifo_data | output | 40 | Last popped pair {left, right} |
| fifo_empty | output | 1 | Queue holds no pair |
| fifo_full | output | 1 | Queue holds 8 pairs |
| fifo_underrun | output | 1 | Sticky: a pop was attempted on an empty queue |

## Verification
Several properties are checked on every cycle. These are:
- the single-cycle results strobe and its fixed distance from the accepted frame close;
- that a frame never starts while the queue is full;
- the cap on the voice count and that no voice is added outside an open frame;
- the empty/full exclusion;
- the stickiness and held data of an underrun;
- that every 16-bit result lies within the 16-bit range.

Only the bench scenarios can show the numeric behaviour: the exact sums, half-up rounding at both widths, clamping of 64 full-scale voices, dropping of the 65th and later voices, and the inclusion of a voice that arrives together with the frame close. The same applies to queue order across a full fill and drain, and to the stall releasing once the codec side has read.

// File: rtl/mixbus_pkg.sv
`timescale 1ns/1ps
package mixbus_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_ACCUM  = 2'd1,
    SEQ_FINISH = 2'd2
  } seq_state_t;

  // Lane numbering of the voice and result vectors.
  localparam int LANE_MAIN_L = 0;
  localparam int LANE_MAIN_R = 1;

  // Drop `drop` LSBs with half-up rounding, then clamp to a signed
  // `width`-bit range. The result is returned at full precision.
  function automatic longint round_sat(input longint value, input int drop,
                                       input int width);
    longint shifted;
    longint hi;
    longint lo;
    shifted = (value + (longint'(1) <<< (drop - 1))) >>> drop;
    hi = (longint'(1) <<< (width - 1)) - 1;
    lo = -(longint'(1) <<< (width - 1));
    if (shifted > hi) return hi;
    if (shifted < lo) return lo;
    return shifted;
  endfunction

endpackage

// File: rtl/mix_lane.sv
`timescale 1ns/1ps
module mix_lane #(
  parameter int VOICE_W     = 18,
  parameter int ACC_W       = 26,
  parameter int OUT_W       = 20,
  parameter int NARROW_W    = 16,
  parameter int DROP_WIDE   = 2,
  parameter int DROP_NARROW = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               add,
  input  logic               latch,
  input  logic               fmt_wide,
  input  logic [VOICE_W-1:0] sample,
  output logic [OUT_W-1:0]   word_next,
  output logic [OUT_W-1:0]   word_q
);
  import mixbus_pkg::*;

  localparam int EXT_W = ACC_W - VOICE_W;

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] sample_ext;
  longint                  reduced;

  assign sample_ext = {{EXT_W{sample[VOICE_W-1]}}, sample};

  always_ff @(posedge clk) begin
    if (!rst_n)     acc_q <= '0;
    else if (clr)   acc_q <= '0;
    else if (add)   acc_q <= acc_q + sample_ext;
  end

  always_comb begin
    if (fmt_wide) reduced = round_sat(longint'(acc_q), DROP_WIDE, OUT_W);
    else          reduced = round_sat(longint'(acc_q), DROP_NARROW, NARROW_W);
    word_next = OUT_W'(reduced);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      word_q <= '0;
    else if (latch)  word_q <= word_next;
  end

endmodule

// File: rtl/mix_seq.sv
`timescale 1ns/1ps
module mix_seq #(
  parameter int MAX_VOICES = 64,
  parameter int CNT_W      = $clog2(MAX_VOICES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             frame_done,
  input  logic             voice_valid,
  input  logic             queue_full,
  output logic             ready,
  output logic             start_fire,
  output logic             add_fire,
  output logic             done_fire,
  output logic             finish,
  output logic             results_valid,
  output logic [CNT_W-1:0] voice_cnt
);
  import mixbus_pkg::*;

  seq_state_t state_q;
  seq_state_t state_d;

  assign ready      = (state_q == SEQ_IDLE) && !queue_full;
  assign start_fire = frame_start && ready;
  assign add_fire   = (state_q == SEQ_ACCUM) && voice_valid &&
                      (voice_cnt < CNT_W'(MAX_VOICES));
  assign done_fire  = (state_q == SEQ_ACCUM) && frame_done;
  assign finish     = (state_q == SEQ_FINISH);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:   if (start_fire) state_d = SEQ_ACCUM;
      SEQ_ACCUM:  if (done_fire)  state_d = SEQ_FINISH;
      SEQ_FINISH: state_d = SEQ_IDLE;
      default:    state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q       <= SEQ_IDLE;
      voice_cnt     <= '0;
      results_valid <= 1'b0;
    end else begin
      state_q       <= state_d;
      results_valid <= finish;
      if (start_fire)    voice_cnt <= '0;
      else if (add_fire) voice_cnt <= voice_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/mix_fifo.sv
`timescale 1ns/1ps
module mix_fifo #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              full,
  output logic              underrun,
  output logic              pop_ok
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr;
  logic [AW-1:0]     rptr;
  logic [CW-1:0]     count;

  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign pop_ok = pop && !empty;

  always_ff @(posedge clk) begin
    if (push && !full) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      rd_data  <= '0;
      underrun <= 1'b0;
    end else begin
      if (push && !full) wptr <= wptr + 1'b1;
      if (pop_ok) begin
        rd_data <= mem[rptr];
        rptr    <= rptr + 1'b1;
      end
      if (pop && empty) underrun <= 1'b1;
      count <= count + CW'(push && !full) - CW'(pop_ok);
    end
  end

endmodule

// File: rtl/voice_bus_mixer.sv
`timescale 1ns/1ps
module voice_bus_mixer #(
  parameter int VOICE_W     = 18,
  parameter int ACC_W       = 26,
  parameter int OUT_W       = 20,
  parameter int NARROW_W    = 16,
  parameter int LANES       = 6,
  parameter int MAX_VOICES  = 64,
  parameter int FIFO_DEPTH  = 8,
  parameter int DROP_WIDE   = 2,
  parameter int DROP_NARROW = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fmt_wide,
  input  logic                     frame_start,
  input  logic                     frame_done,
  input  logic                     voice_valid,
  input  logic [LANES*VOICE_W-1:0] voice_lanes,
  output logic                     frame_ready,
  output logic                     out_valid,
  output logic [LANES*OUT_W-1:0]   bus_out,
  input  logic                     fifo_rd,
  output logic [2*OUT_W-1:0]       fifo_data,
  output logic                     fifo_empty,
  output logic                     fifo_full,
  output logic                     fifo_underrun
);
  import mixbus_pkg::*;

  localparam int CNT_W = $clog2(MAX_VOICES + 1);

  // Internal events, named for the checker.
  logic             start_fire;
  logic             add_fire;
  logic             done_fire;
  logic             finish;
  logic             pop_ok;
  logic [CNT_W-1:0] voice_cnt;

  logic [OUT_W-1:0] lane_next [LANES];
  logic [OUT_W-1:0] lane_q    [LANES];

  mix_seq #(
    .MAX_VOICES (MAX_VOICES),
    .CNT_W      (CNT_W)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start   (frame_start),
    .frame_done    (frame_done),
    .voice_valid   (voice_valid),
    .queue_full    (fifo_full),
    .ready         (frame_ready),
    .start_fire    (start_fire),
    .add_fire      (add_fire),
    .done_fire     (done_fire),
    .finish        (finish),
    .results_valid (out_valid),
    .voice_cnt     (voice_cnt)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    mix_lane #(
      .VOICE_W     (VOICE_W),
      .ACC_W       (ACC_W),
      .OUT_W       (OUT_W),
      .NARROW_W    (NARROW_W),
      .DROP_WIDE   (DROP_WIDE),
      .DROP_NARROW (DROP_NARROW)
    ) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (start_fire),
      .add       (add_fire),
      .latch     (finish),
      .fmt_wide  (fmt_wide),
      .sample    (voice_lanes[g*VOICE_W +: VOICE_W]),
      .word_next (lane_next[g]),
      .word_q    (lane_q[g])
    );
    assign bus_out[g*OUT_W +: OUT_W] = lane_q[g];
  end

  mix_fifo #(
    .DEPTH  (FIFO_DEPTH),
    .DATA_W (2*OUT_W)
  ) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (finish),
    .push_data ({lane_next[LANE_MAIN_L], lane_next[LANE_MAIN_R]}),
    .pop       (fifo_rd),
    .rd_data   (fifo_data),
    .empty     (fifo_empty),
    .full      (fifo_full),
    .underrun  (fifo_underrun),
    .pop_ok    (pop_ok)
  );

endmodule

// File: rtl/voice_bus_mixer_chk.sv
`timescale 1ns/1ps
module voice_bus_mixer_chk #(
  parameter int MAX_VOICES = 64,
  parameter int CNT_W      = 7,
  parameter int OUT_W      = 20,
  parameter int NARROW_W   = 16,
  parameter int LANES      = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   fmt_wide,
  input logic                   frame_ready,
  input logic                   out_valid,
  input logic [LANES*OUT_W-1:0] bus_out,
  input logic                   fifo_rd,
  input logic [2*OUT_W-1:0]     fifo_data,
  input logic                   fifo_empty,
  input logic                   fifo_full,
  input logic                   fifo_underrun,
  input logic                   start_fire,
  input logic                   add_fire,
  input logic                   done_fire,
  input logic [CNT_W-1:0]       voice_cnt
);
  localparam int TOP_W = OUT_W - NARROW_W + 1;

  AST_OUT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);                                    // R6
  AST_OUT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(done_fire, 2));                           // R6
  AST_START_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    start_fire |-> !fifo_full);                                   // R8
  AST_VOICE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    voice_cnt <= CNT_W'(MAX_VOICES));                             // R3
  AST_ADD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    add_fire |-> !frame_ready);                                   // R11
  AST_EMPTY_FULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));                                  // R7
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_underrun |=> fifo_underrun);                             // R10
  AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rd && fifo_empty) |=> (fifo_underrun && $stable(fifo_data))); // R10

  for (genvar g = 0; g < LANES; g++) begin : g_range
    AST_NARROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !$past(fmt_wide)) |->
        ((bus_out[g*OUT_W + NARROW_W - 1 +: TOP_W] == '0) ||
         (bus_out[g*OUT_W + NARROW_W - 1 +: TOP_W] == '1)));      // R5
  end

endmodule

bind voice_bus_mixer voice_bus_mixer_chk #(
  .MAX_VOICES (MAX_VOICES),
  .CNT_W      (CNT_W),
  .OUT_W      (OUT_W),
  .NARROW_W   (NARROW_W),
  .LANES      (LANES)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fmt_wide      (fmt_wide),
  .frame_ready   (frame_ready),
  .out_valid     (out_valid),
  .bus_out       (bus_out),
  .fifo_rd       (fifo_rd),
  .fifo_data     (fifo_data),
  .fifo_empty    (fifo_empty),
  .fifo_full     (fifo_full),
  .fifo_underrun (fifo_underrun),
  .start_fire    (start_fire),
  .add_fire      (add_fire),
  .done_fire     (done_fire),
  .voice_cnt     (voice_cnt)
);

// File: tb/voice_bus_mixer_bench.sv
`timescale 1ns/1ps
module voice_bus_mixer_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fmt_wide = 1'b1;
  logic         frame_start = 1'b0;
  logic         frame_done = 1'b0;
  logic         voice_valid = 1'b0;
  logic [107:0] voice_lanes = '0;
  logic         frame_ready;
  logic         out_valid;
  logic [119:0] bus_out;
  logic         fifo_rd = 1'b0;
  logic [39:0]  fifo_data;
  logic         fifo_empty;
  logic         fifo_full;
  logic         fifo_underrun;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Scoreboard state.
  logic [119:0] exp_bus[$];
  logic [39:0]  exp_fifo[$];
  logic [39:0]  last_pair = '0;
  longint       m_acc[6];
  int           m_cnt = 0;
  bit           m_open = 1'b0;

  always #5 clk = ~clk;

  voice_bus_mixer u_voice_bus_mixer (
    .clk(clk), .rst_n(rst_n), .fmt_wide(fmt_wide), .frame_start(frame_start),
    .frame_done(frame_done), .voice_valid(voice_valid), .voice_lanes(voice_lanes),
    .frame_ready(frame_ready), .out_valid(out_valid), .bus_out(bus_out),
    .fifo_rd(fifo_rd), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
    .fifo_full(fifo_full), .fifo_underrun(fifo_underrun)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Reference reduction by floor division and explicit clamping.
  function automatic logic [19:0] ref_fmt(input longint a, input bit wide);
    longint d;
    longint n;
    longint q;
    longint top;
    d   = wide ? 64'sd4 : 64'sd64;
    top = wide ? 64'sd524288 : 64'sd32768;
    n   = a + d / 2;
    if (n >= 0) q = n / d;
    else        q = -((-n + d - 1) / d);
    if (q > top - 1) q = top - 1;
    if (q < -top)    q = -top;
    return 20'(q);
  endfunction

  task automatic finish_expect();
    logic [119:0] e;
    for (int i = 0; i < 6; i++) e[i*20 +: 20] = ref_fmt(m_acc[i], fmt_wide);
    exp_bus.push_back(e);
    exp_fifo.push_back({e[19:0], e[39:20]});
    m_open = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic begin_frame(input bit expect_ok);
    check(frame_ready == expect_ok, "R8", "frame_ready before start",
          128'(frame_ready), 128'(expect_ok));
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    if (expect_ok) begin
      m_open = 1'b1;
      m_cnt = 0;
      for (int i = 0; i < 6; i++) m_acc[i] = 0;
    end
  endtask

  task automatic voice(input int v0, input int v1, input int v2, input int v3,
                       input int v4, input int v5, input bit with_done);
    int v[6];
    v = '{v0, v1, v2, v3, v4, v5};
    for (int i = 0; i < 6; i++) voice_lanes[i*18 +: 18] = 18'(v[i]);
    voice_valid = 1'b1;
    frame_done = with_done;
    if (m_open) begin
      if (m_cnt < 64) for (int i = 0; i < 6; i++) m_acc[i] += longint'(v[i]);
      m_cnt++;
    end
    @(negedge clk);
    voice_valid = 1'b0;
    frame_done = 1'b0;
    voice_lanes = '0;
    if (with_done && m_open) finish_expect();
  endtask

  task automatic end_frame();
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
    if (m_open) finish_expect();
    idle(3);
  endtask

  task automatic read_fifo();
    bit was_empty;
    logic [39:0] e;
    was_empty = (exp_fifo.size() == 0);
    check(fifo_empty == was_empty, "R9", "fifo_empty before read",
          128'(fifo_empty), 128'(was_empty));
    fifo_rd = 1'b1;
    @(negedge clk);
    fifo_rd = 1'b0;
    if (!was_empty) begin
      e = exp_fifo.pop_front();
      check(fifo_data == e, "R7 R9", "popped main pair", 128'(fifo_data), 128'(e));
      last_pair = e;
    end else begin
      check(fifo_data == last_pair, "R10", "data after empty read",
            128'(fifo_data), 128'(last_pair));
      check(fifo_underrun == 1'b1, "R10", "underrun flag", 128'(fifo_underrun), 128'(1));
    end
  endtask

  // Monitor: compare every result strobe against the scoreboard (R2..R6).
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_bus.size() == 0) begin
        check(1'b0, "R11", "unexpected out_valid", 128'(bus_out), 128'(0));
      end else begin
        logic [119:0] e;
        e = exp_bus.pop_front();
        check(bus_out == e, "R2 R4 R5 R6", "bus_out at strobe", 128'(bus_out), 128'(e));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(frame_ready == 1'b1, "R1", "frame_ready", 128'(frame_ready), 128'(1));
    check(fifo_empty == 1'b1 && fifo_full == 1'b0, "R1", "empty/full",
          128'({fifo_empty, fifo_full}), 128'(2'b10));
    check(out_valid == 1'b0 && fifo_underrun == 1'b0, "R1", "valid/underrun",
          128'({out_valid, fifo_underrun}), 128'(0));
    check(bus_out == '0 && fifo_data == '0, "R1", "data outputs",
          128'(bus_out), 128'(0));

    // R2 R4: mixed signs, half-up rounding at 20 bits (6 -> 2, -6 -> -1)
    fmt_wide = 1'b1;
    begin_frame(1'b1);
    voice(5, -5, 100, -100, 1, -2, 1'b0);
    voice(1, -1, 3, -3, 0, 7, 1'b0);
    voice(0, 0, -200, 2000, 130000, -130000, 1'b0);
    end_frame();

    // R2 R5: 16-bit mode, 32 -> 1, -32 -> 0, 96 -> 2
    fmt_wide = 1'b0;
    begin_frame(1'b1);
    voice(32, -32, 96, -96, 31, 100000, 1'b0);
    voice(0, 0, 0, 0, 0, 100000, 1'b0);
    end_frame();

    // R4 R5: clamping with 64 full-scale voices, both widths
    for (int m = 0; m < 2; m++) begin
      fmt_wide = (m == 0);
      begin_frame(1'b1);
      for (int i = 0; i < 64; i++) voice(131071, -131072, 40000, -40000, 8191, -8, 1'b0);
      end_frame();
    end

    // R3: 70 voices, only 64 counted
    fmt_wide = 1'b1;
    begin_frame(1'b1);
    for (int i = 0; i < 70; i++) voice(1000, -1000, 500, 0, 0, 7, 1'b0);
    end_frame();

    // R11: voice and frame_done outside a frame are ignored
    voice(9999, 9999, 9999, 9999, 9999, 9999, 1'b0);
    end_frame();
    // R8: start during a frame is ignored; R2: voice on the done cycle counts
    begin_frame(1'b1);
    voice(400, 8, -12, 0, 2, 2, 1'b0);
    begin_frame(1'b0);
    voice(4, 400, 12, 1, 2, 2, 1'b1);
    idle(3);

    // R7 R9: drain six pairs in order
    for (int i = 0; i < 6; i++) read_fifo();
    check(fifo_underrun == 1'b0, "R10", "no underrun yet", 128'(fifo_underrun), 128'(0));

    // R8: fill the queue, then the next start is refused
    for (int k = 1; k <= 8; k++) begin
      begin_frame(1'b1);
      voice(k * 1000 + 6, -k * 4, k, 0, 0, -k, 1'b0);
      end_frame();
    end
    check(fifo_full == 1'b1, "R8", "queue full after 8 frames", 128'(fifo_full), 128'(1));
    begin_frame(1'b0);
    voice(77, 77, 77, 77, 77, 77, 1'b0);
    end_frame();

    for (int i = 0; i < 8; i++) read_fifo();
    read_fifo();      // R10 empty read
    read_fifo();      // R10 stays sticky, data held
    idle(1);
    check(fifo_underrun == 1'b1, "R10", "underrun sticky", 128'(fifo_underrun), 128'(1));

    // R8: stall released after draining
    begin_frame(1'b1);
    voice(-7, 7, 0, 0, 0, 0, 1'b1);
    idle(3);
    read_fifo();

    check(exp_bus.size() == 0, "R6", "all strobes seen",
          128'(exp_bus.size()), 128'(0));
    done = 1'b1;
    summary();
    $finish;
  end

endmodule